// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept, judging only by its 48-bit destination address and its length. It holds a table of sixteen exact-match addresses. Software loads the table by streaming a 192-byte setup frame into the block one byte per beat. A lookup request carries the destination address and the frame length. One cycle later the block returns a keep/drop verdict with two qualifier flags. One flag marks a frame kept only because filtering was bypassed. The other marks a frame kept only because it is multicast.

The decision follows a fixed order. A length outside the legal window always drops the frame. The broadcast address is always kept. A bypass mode keeps any other address. A pass-multicast mode keeps group addresses. Anything left over is checked against the table, and an inverse mode flips that last result. The address is presented with its first byte on the wire in bits 47:40.

Both input streams use valid/ready. The setup stream and the lookup stream never apply back-pressure: each ready output is low during reset and high in every cycle after it. A beat is taken on any clock edge where valid and ready are both high. The result port has no ready. It is a single-cycle pulse that the consumer must take when it appears.

Top module: `dst_addr_filter`

## Requirements
- R1: A lookup accepted at a clock edge produces `res_valid` high for exactly that one following cycle. With no lookup accepted, `res_valid` stays low.
- R2: The table is replaced only when a setup frame ends (`setup_last` on its final beat) after exactly 192 accepted bytes. Frames of any other length leave every entry unchanged. The new contents are in use for lookups starting two cycles after the final beat.
- R3: Entry n is built from setup-frame byte offsets 12n+0, 12n+1, 12n+4, 12n+5, 12n+8 and 12n+9. These become address bits 47:40, 39:32, 31:24, 23:16, 15:8 and 7:0 in that order. All other offsets are ignored.
- R4: Reset clears every table entry to zero, so an all-zero address matches until the first load. `res_valid` and both ready outputs are low while reset is held.
- R5: The all-ones address is accepted whatever the modes, with both flags low.
- R6: When bypass (`mode_promisc`) or receive-all (`mode_rx_all`) is set, any non-broadcast address is accepted with `res_promisc_flag` high.
- R7: When `mode_pass_mcast` is set and address bit 40 is 1, the frame is accepted with `res_mcast_flag` high.
- R8: Otherwise the frame is accepted exactly when the address equals some table entry. Both flags are low.
- R9: With `mode_inverse` set, the table result of R8 is inverted. Inversion does not affect R5 to R7.
- R10: A length below 14 or above 2044 is rejected with both flags low, whatever the address or modes. The lengths 14 and 2044 themselves are legal.
- R11: `setup_ready` and `req_ready` are high in every cycle after reset is released.
- R12: The checks have a fixed priority: broadcast first, then bypass, then pass-multicast, then the table. At most one flag is high, and a flag is never high on a rejected frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Setup byte present |
| setup_ready | output | 1 | Setup byte can be taken |
| setup_data | input | 8 | Setup frame byte |
| setup_last | input | 1 | Final byte of the setup frame |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | 48 | Destination address, first wire byte in 47:40 |
| req_len | input | 12 | Frame length in bytes |
| mode_promisc | input | 1 | Bypass filtering |
| mode_rx_all | input | 1 | Receive all frames |
| mode_pass_mcast | input | 1 | Keep every multicast address |
| mode_inverse | input | 1 | Invert the table match |
| res_valid | output | 1 | Verdict pulse |
| res_accept | output | 1 | Frame kept |
| res_promisc_flag | output | 1 | Kept by bypass or receive-all |
| res_mcast_flag | output | 1 | Kept by pass-multicast |

## Verification
A lookup driven before a rising edge has its verdict and flags registered at that edge. The bench drives requests on falling edges and samples on the next falling edge. It then checks that `res_valid` has dropped one cycle later. The final byte of a setup frame raises an internal commit at the following edge, and the table changes one edge after that. Each load sequence therefore waits two full cycles before its first lookup. All table checks, including those after short or long setup frames, fall on the far side of that two-edge window.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int MAC_W      = 48;
  localparam int SLOT_BYTES = 12;
  typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/daf_setup_loader.sv
module daf_setup_loader
  import daf_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  input  logic [7:0]            s_data,
  input  logic                  s_last,
  output logic                  s_ready,
  output logic                  commit,
  output mac_t [N_ENTRIES-1:0]  shadow
);
  localparam int FRAME_BYTES = N_ENTRIES * SLOT_BYTES;
  localparam int CNT_W       = $clog2(FRAME_BYTES + 1) + 1;
  localparam int IW          = $clog2(N_ENTRIES);

  logic [CNT_W-1:0] cnt;
  logic [3:0]       phase;
  logic [IW-1:0]    ent;
  logic             fire;
  logic             slot_used;
  logic [5:0]       slot_sh;
  logic             wr_en;

  assign fire = s_valid & s_ready;

  // map the position within a 12-byte slot to an address byte lane
  always_comb begin
    slot_used = 1'b1;
    unique case (phase)
      4'd0:    slot_sh = 6'd40;
      4'd1:    slot_sh = 6'd32;
      4'd4:    slot_sh = 6'd24;
      4'd5:    slot_sh = 6'd16;
      4'd8:    slot_sh = 6'd8;
      4'd9:    slot_sh = 6'd0;
      default: begin slot_sh = 6'd0; slot_used = 1'b0; end
    endcase
  end

  assign wr_en = fire && slot_used && (cnt < CNT_W'(FRAME_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      phase   <= '0;
      ent     <= '0;
      s_ready <= 1'b0;
      commit  <= 1'b0;
    end else begin
      s_ready <= 1'b1;
      commit  <= fire && s_last && (cnt == CNT_W'(FRAME_BYTES - 1));
      if (fire) begin
        if (s_last) begin
          cnt   <= '0;
          phase <= '0;
          ent   <= '0;
        end else begin
          if (cnt != CNT_W'(FRAME_BYTES)) cnt <= cnt + 1'b1;
          if (phase == 4'(SLOT_BYTES - 1)) begin
            phase <= '0;
            ent   <= ent + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[i] <= '0;
      end else if (wr_en && (ent == IW'(i))) begin
        shadow[i][slot_sh +: 8] <= s_data;
      end
    end
  end

  // R2: a commit only follows a beat that closed a frame
  assert_commit_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(s_valid && s_last));

endmodule

// File: rtl/daf_match_table.sv
module daf_match_table
  import daf_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  mac_t [N_ENTRIES-1:0]  shadow,
  input  mac_t                  look_addr,
  output logic                  hit
);
  mac_t [N_ENTRIES-1:0] entries_q;
  logic [N_ENTRIES-1:0] match;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)      entries_q[i] <= '0;
      else if (commit) entries_q[i] <= shadow[i];
    end
    assign match[i] = (entries_q[i] == look_addr);
  end

  assign hit = |match;

  // R2: the live table takes the staged copy on commit and holds otherwise
  assert_commit_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit) |-> (entries_q == $past(shadow)));
  assert_table_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(entries_q));

endmodule

// File: rtl/daf_decide.sv
module daf_decide
  import daf_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 2044
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  mac_t             req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             mode_promisc,
  input  logic             mode_rx_all,
  input  logic             mode_pass_mcast,
  input  logic             mode_inverse,
  input  logic             hit,
  output logic             req_ready,
  output logic             res_valid,
  output logic             res_accept,
  output logic             res_promisc_flag,
  output logic             res_mcast_flag
);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_LEN);

  logic len_ok, is_bcast, is_group;
  logic acc_d, fp_d, fm_d;
  logic take;

  assign take     = req_valid & req_ready;
  assign len_ok   = (req_len >= LEN_LO) && (req_len <= LEN_HI);
  assign is_bcast = &req_addr;
  assign is_group = req_addr[40];

  always_comb begin
    acc_d = 1'b0;
    fp_d  = 1'b0;
    fm_d  = 1'b0;
    if (!len_ok) begin
      acc_d = 1'b0;
    end else if (is_bcast) begin
      acc_d = 1'b1;
    end else if (mode_promisc || mode_rx_all) begin
      acc_d = 1'b1;
      fp_d  = 1'b1;
    end else if (mode_pass_mcast && is_group) begin
      acc_d = 1'b1;
      fm_d  = 1'b1;
    end else begin
      acc_d = hit ^ mode_inverse;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ready        <= 1'b0;
      res_valid        <= 1'b0;
      res_accept       <= 1'b0;
      res_promisc_flag <= 1'b0;
      res_mcast_flag   <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      res_valid <= take;
      if (take) begin
        res_accept       <= acc_d;
        res_promisc_flag <= fp_d;
        res_mcast_flag   <= fm_d;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !res_valid);
  assert_len_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ((req_len < LEN_LO) || (req_len > LEN_HI)))
      |=> (!res_accept && !res_promisc_flag && !res_mcast_flag));
  assert_bcast_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && len_ok && (&req_addr))
      |=> (res_accept && !res_promisc_flag && !res_mcast_flag));
  assert_one_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0({res_promisc_flag, res_mcast_flag}));
  assert_flag_implies_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_promisc_flag || res_mcast_flag)) |-> res_accept);
  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && len_ok && !(&req_addr) && (mode_promisc || mode_rx_all))
      |=> (res_accept && res_promisc_flag));

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import daf_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int LEN_W     = 12,
  parameter int MIN_LEN   = 14,
  parameter int MAX_LEN   = 2044
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  output logic             setup_ready,
  input  logic [7:0]       setup_data,
  input  logic             setup_last,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [47:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             mode_promisc,
  input  logic             mode_rx_all,
  input  logic             mode_pass_mcast,
  input  logic             mode_inverse,
  output logic             res_valid,
  output logic             res_accept,
  output logic             res_promisc_flag,
  output logic             res_mcast_flag
);
  mac_t [N_ENTRIES-1:0] shadow;
  logic                 commit;
  logic                 hit;

  daf_setup_loader #(.N_ENTRIES(N_ENTRIES)) u_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (setup_valid),
    .s_data  (setup_data),
    .s_last  (setup_last),
    .s_ready (setup_ready),
    .commit  (commit),
    .shadow  (shadow)
  );

  daf_match_table #(.N_ENTRIES(N_ENTRIES)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .shadow    (shadow),
    .look_addr (req_addr),
    .hit       (hit)
  );

  daf_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_decide (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_addr         (req_addr),
    .req_len          (req_len),
    .mode_promisc     (mode_promisc),
    .mode_rx_all      (mode_rx_all),
    .mode_pass_mcast  (mode_pass_mcast),
    .mode_inverse     (mode_inverse),
    .hit              (hit),
    .req_ready        (req_ready),
    .res_valid        (res_valid),
    .res_accept       (res_accept),
    .res_promisc_flag (res_promisc_flag),
    .res_mcast_flag   (res_mcast_flag)
  );

endmodule

// File: tb/dst_addr_filter_test.sv
`timescale 1ns/1ps
module dst_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_valid = 1'b0, setup_last = 1'b0;
  logic [7:0]  setup_data = '0;
  logic        setup_ready;
  logic        req_valid = 1'b0;
  logic [47:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic        mode_promisc = 0, mode_rx_all = 0, mode_pass_mcast = 0, mode_inverse = 0;
  logic        req_ready, res_valid, res_accept, res_promisc_flag, res_mcast_flag;
  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  dst_addr_filter uut (
    .clk(clk), .rst_n(rst_n),
    .setup_valid(setup_valid), .setup_ready(setup_ready),
    .setup_data(setup_data), .setup_last(setup_last),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .mode_promisc(mode_promisc), .mode_rx_all(mode_rx_all),
    .mode_pass_mcast(mode_pass_mcast), .mode_inverse(mode_inverse),
    .res_valid(res_valid), .res_accept(res_accept),
    .res_promisc_flag(res_promisc_flag), .res_mcast_flag(res_mcast_flag)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // setup frame byte at offset o; used lanes carry entry data, others filler
  function automatic logic [7:0] fbyte(int o, int salt);
    int n = o / 12;
    int k = o % 12;
    int p;
    case (k)
      0: p = 0; 1: p = 1; 4: p = 2; 5: p = 3; 8: p = 4; 9: p = 5;
      default: p = -1;
    endcase
    if (p < 0) return 8'h5A;
    return 8'(n * 16 + p * 2 + 2 + salt);
  endfunction

  function automatic logic [47:0] entry_addr(int n, int salt);
    int b = 12 * n;
    return {fbyte(b, salt), fbyte(b+1, salt), fbyte(b+4, salt),
            fbyte(b+5, salt), fbyte(b+8, salt), fbyte(b+9, salt)};
  endfunction

  task automatic send_setup(int nbytes, int salt);
    for (int o = 0; o < nbytes; o++) begin
      @(negedge clk);
      if (o == 0) chk("R11 setup_ready", setup_ready, 1);
      setup_valid = 1'b1;
      setup_data  = fbyte(o, salt);
      setup_last  = (o == nbytes - 1);
    end
    @(negedge clk);
    setup_valid = 1'b0;
    setup_last  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic lookup(logic [47:0] a, int len, bit acc, bit fp, bit fm, string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_len   = 12'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, res_valid, 1);
    chk({tag, " accept"}, res_accept, acc);
    chk({tag, " promisc flag"}, res_promisc_flag, fp);
    chk({tag, " mcast flag"}, res_mcast_flag, fm);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R4 res_valid in reset", res_valid, 0);
    chk("R4 setup_ready in reset", setup_ready, 0);
    chk("R4 req_ready in reset", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 req_ready", req_ready, 1);
    chk("R11 setup_ready", setup_ready, 1);
    lookup(48'h0, 64, 1, 0, 0, "R4 zero entry matches");
    @(negedge clk);
    chk("R1 idle after result", res_valid, 0);
    lookup(48'h02AABBCCDDEE, 64, 0, 0, 0, "R8 unknown before load");
  endtask

  task automatic t_load;
    send_setup(192, 0);
    lookup(entry_addr(0, 0), 100, 1, 0, 0, "R3 entry 0");
    lookup(entry_addr(7, 0), 100, 1, 0, 0, "R3 entry 7");
    lookup(entry_addr(15, 0), 100, 1, 0, 0, "R3 entry 15");
    lookup(48'h0, 100, 0, 0, 0, "R2 zero replaced");
    lookup({fbyte(36,0), fbyte(37,0), fbyte(38,0), fbyte(39,0), fbyte(40,0), fbyte(41,0)},
           100, 0, 0, 0, "R3 skipped offsets");
  endtask

  task automatic t_bad_len;
    send_setup(191, 1);
    lookup(entry_addr(5, 1), 100, 0, 0, 0, "R2 short frame ignored");
    lookup(entry_addr(5, 0), 100, 1, 0, 0, "R2 short frame keeps old");
    send_setup(193, 1);
    lookup(entry_addr(5, 1), 100, 0, 0, 0, "R2 long frame ignored");
    lookup(entry_addr(5, 0), 100, 1, 0, 0, "R2 long frame keeps old");
  endtask

  task automatic t_bcast;
    mode_inverse = 1;
    lookup(48'hFFFFFFFFFFFF, 60, 1, 0, 0, "R5 broadcast with inverse");
    mode_inverse = 0; mode_promisc = 1; mode_pass_mcast = 1;
    lookup(48'hFFFFFFFFFFFF, 60, 1, 0, 0, "R5 broadcast no flags");
    mode_promisc = 0; mode_pass_mcast = 0;
  endtask

  task automatic t_bypass;
    mode_promisc = 1;
    lookup(48'h02AABBCCDDEE, 60, 1, 1, 0, "R6 promisc");
    mode_promisc = 0; mode_rx_all = 1;
    lookup(48'h02AABBCCDDEE, 60, 1, 1, 0, "R6 rx_all");
    mode_rx_all = 0;
  endtask

  task automatic t_mcast;
    mode_pass_mcast = 1;
    lookup(48'h01005E000001, 60, 1, 0, 1, "R7 group address");
    lookup(48'h02AABBCCDDEE, 60, 0, 0, 0, "R7 unicast not passed");
    mode_pass_mcast = 0;
    lookup(48'h01005E000001, 60, 0, 0, 0, "R8 group without pass");
  endtask

  task automatic t_inverse;
    mode_inverse = 1;
    lookup(entry_addr(3, 0), 60, 0, 0, 0, "R9 listed rejected");
    lookup(48'h02AABBCCDDEE, 60, 1, 0, 0, "R9 unlisted kept");
    mode_pass_mcast = 1;
    lookup(48'h01005E000001, 60, 1, 0, 1, "R12 mcast before inverse");
    mode_inverse = 0; mode_pass_mcast = 0;
  endtask

  task automatic t_priority;
    mode_promisc = 1; mode_pass_mcast = 1;
    lookup(48'h01005E000001, 60, 1, 1, 0, "R12 bypass over mcast");
    mode_pass_mcast = 0;
    lookup(entry_addr(2, 0), 60, 1, 1, 0, "R12 bypass over table");
    mode_promisc = 0;
  endtask

  task automatic t_length;
    mode_promisc = 1;
    lookup(48'h02AABBCCDDEE, 13, 0, 0, 0, "R10 len 13");
    lookup(48'h02AABBCCDDEE, 14, 1, 1, 0, "R10 len 14");
    lookup(48'h02AABBCCDDEE, 2044, 1, 1, 0, "R10 len 2044");
    mode_promisc = 0;
    lookup(48'hFFFFFFFFFFFF, 2045, 0, 0, 0, "R10 len 2045 broadcast");
    lookup(entry_addr(1, 0), 0, 0, 0, 0, "R10 len 0 listed");
  endtask

  initial begin
    t_reset();
    t_load();
    t_bad_len();
    t_bcast();
    t_bypass();
    t_mcast();
    t_inverse();
    t_priority();
    t_length();
    @(negedge clk);
    chk("R1 no stray result", res_valid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule